// File: doc/BRIEF.md
# Single-Cycle Six-Instruction RISC Core

This block is a 32-bit processor core in which every instruction is fetched, decoded, executed and retired within one clock cycle. It implements six instructions: unsigned register add, unsigned register subtract, OR with a zero-extended immediate, word load, word store, and branch when two registers are equal. The core contains the program counter, a 32 x 32 register file with two read ports and one write port, the immediate widener, an ALU with a zero flag, separate adders for the sequential and branch program counters, and the control decoder.

The core drives a word-wide instruction fetch address and reads the instruction word back in the same cycle. Its data port presents a byte address, write data and a write strobe, and it takes load data back in the same cycle. Both memories sit outside the core. Each is expected to read combinationally and to write on the rising clock edge. The data memory selects a word with address bits [9:2].

Top module: `sc6_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 at the next rising edge. The register file keeps its contents through reset.
- R2: With opcode 6'h00, funct 6'h21 writes rs+rt to rd and funct 6'h23 writes rs-rt to rd. Both wrap modulo 2^32. The R-type fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 6'h0D writes rs OR the zero-extended imm16 (bits [15:0]) to rt.
- R4: Opcode 6'h23 drives dmem_addr with rs + sign-extended imm16 and writes dmem_rdata to rt.
- R5: Opcode 6'h2B drives dmem_we high, dmem_addr with rs + sign-extended imm16, and dmem_wdata with rt. It writes no register. Every other instruction holds dmem_we low.
- R6: With opcode 6'h04, the next PC is PC+4+(sign-extended imm16 << 2) when rs equals rt, and PC+4 otherwise.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: Any other opcode, and opcode 6'h00 with any other funct, changes no register and no memory and advances the PC by 4.
- R9: imem_addr equals the PC. The PC advances by 4 after every instruction that is not a taken branch, so it stays word-aligned.
- R10: An instruction that reads the register it writes uses the value held before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch byte address (the PC) |
| imem_data | input | 32 | Instruction word read from imem_addr |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by the memory at the rising edge |
| dmem_rdata | input | 32 | Load data read combinationally from dmem_addr |

## Verification
The assertions assume that imem_data carries a defined word in every cycle after reset. They also assume that the registers an instruction compares have been written before any branch reads them, because reset leaves the register file undefined. The stimulus first writes every register with an OR-immediate from register 0. After that it issues a seeded random mix of all six instructions plus illegal encodings, and in every cycle it drives a fully specified instruction word. The directed cases cover a write to register 0, a top-bit immediate under zero extension, a subtraction that wraps, a negative load offset, a self-targeting taken branch, and a reset in the middle of the run.

// File: rtl/sc6_pkg.sv
package sc6_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 16;
  localparam int OP_W   = 6;
  localparam int RIDX_W = 5;
  localparam int INSN_B = XLEN / 8;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] FN_ADDU   = 6'h21;
  localparam logic [OP_W-1:0] FN_SUBU   = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    use_imm;
    logic    imm_sext;
    logic    mem_we;
    logic    load;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] alu_eval(alu_op_e op, logic [XLEN-1:0] a,
                                                logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] widen_imm(logic [IMM_W-1:0] imm, logic sext);
    return sext ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} : {{(XLEN-IMM_W){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(logic [XLEN-1:0] pc_seq,
                                                   logic [XLEN-1:0] offs);
    return pc_seq + (offs << 2);
  endfunction
endpackage

// File: rtl/sc6_decode.sv
module sc6_decode
  import sc6_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [OP_W-1:0] funct,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin
        if (funct == FN_ADDU || funct == FN_SUBU) begin
          ctrl.reg_we = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OPC_LOAD: begin
        ctrl.reg_we   = 1'b1;
        ctrl.use_imm  = 1'b1;
        ctrl.imm_sext = 1'b1;
        ctrl.load     = 1'b1;
      end
      OPC_STORE: begin
        ctrl.use_imm  = 1'b1;
        ctrl.imm_sext = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.imm_sext = 1'b1;
        ctrl.branch   = 1'b1;
        ctrl.alu_op   = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc6_regfile.sv
module sc6_regfile
  import sc6_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int W      = XLEN,
  parameter int NREAD  = 2
) (
  input  logic                              clk,
  input  logic                              we,
  input  logic [$clog2(NREG)-1:0]           wa,
  input  logic [W-1:0]                      wd,
  input  logic [NREAD-1:0][$clog2(NREG)-1:0] ra,
  output logic [NREAD-1:0][W-1:0]           rd
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] store [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) store[wa] <= wd;
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_rport
    assign rd[p] = (ra[p] == AW'(0)) ? '0 : store[ra[p]];
  end
endmodule

// File: rtl/sc6_alu.sv
module sc6_alu
  import sc6_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc6_core.sv
module sc6_core
  import sc6_pkg::*;
#(
  parameter int              NREG     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  logic [XLEN-1:0]   pc_q, pc_seq, br_dest, pc_next;
  logic [XLEN-1:0]   rs_val, rt_val, imm_w, alu_b, alu_y, wb_data;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic              alu_zero, branch_taken, reg_we_w, mem_we_w;
  ctrl_t             ctrl;
  logic [1:0][RIDX_W-1:0] rf_ra;
  logic [1:0][XLEN-1:0]   rf_rd;

  assign rs_idx = imem_data[25:21];
  assign rt_idx = imem_data[20:16];
  assign rd_idx = imem_data[15:11];

  sc6_decode u_dec (
    .opcode (imem_data[31:26]),
    .funct  (imem_data[5:0]),
    .ctrl   (ctrl)
  );

  assign rf_ra  = {rt_idx, rs_idx};
  assign rs_val = rf_rd[0];
  assign rt_val = rf_rd[1];
  assign wr_idx = ctrl.dst_rd ? rd_idx : rt_idx;

  sc6_regfile #(.NREG(NREG), .W(XLEN), .NREAD(2)) u_rf (
    .clk (clk),
    .we  (reg_we_w),
    .wa  (wr_idx),
    .wd  (wb_data),
    .ra  (rf_ra),
    .rd  (rf_rd)
  );

  assign imm_w = widen_imm(imem_data[IMM_W-1:0], ctrl.imm_sext);
  assign alu_b = ctrl.use_imm ? imm_w : rt_val;

  sc6_alu u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign reg_we_w     = ctrl.reg_we;
  assign mem_we_w     = ctrl.mem_we;
  assign branch_taken = ctrl.branch & alu_zero;
  assign wb_data      = ctrl.load ? dmem_rdata : alu_y;

  assign pc_seq  = pc_q + XLEN'(INSN_B);
  assign br_dest = branch_dest(pc_seq, imm_w);
  assign pc_next = branch_taken ? br_dest : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = mem_we_w;
endmodule

// File: rtl/sc6_core_chk.sv
module sc6_core_chk
  import sc6_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   imem_addr,
  input logic [RIDX_W-1:0] rs_idx,
  input logic [XLEN-1:0]   rs_val,
  input logic [XLEN-1:0]   rt_val,
  input logic              branch_taken,
  input logic              reg_we,
  input logic              mem_we
);
  AST_PC_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == '0); // R1

  AST_STORE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !reg_we); // R5

  AST_BRANCH_NEEDS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> rs_val == rt_val); // R6

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
    rs_idx == '0 |-> rs_val == '0); // R7

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !branch_taken |=> pc == $past(pc) + XLEN'(INSN_B)); // R9

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00); // R9
endmodule

bind sc6_core sc6_core_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pc           (pc_q),
  .imem_addr    (imem_addr),
  .rs_idx       (rs_idx),
  .rs_val       (rs_val),
  .rt_val       (rt_val),
  .branch_taken (branch_taken),
  .reg_we       (reg_we_w),
  .mem_we       (mem_we_w)
);

// File: tb/sc6_core_test.sv
module sc6_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_STEPS = 3000;
  localparam int MEM_WORDS  = 256;
  localparam int WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [31:0] imem_data = 32'h0;
  logic        dmem_we;

  logic [31:0] dmem    [MEM_WORDS];
  logic [31:0] ref_mem [MEM_WORDS];
  logic [31:0] ref_reg [32];
  logic [31:0] ref_pc;
  string       pc_req = "R9";
  int          errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  sc6_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] rget(logic [4:0] i);
    return (i == 5'd0) ? 32'h0 : ref_reg[i];
  endfunction

  function automatic logic [31:0] enc_r(logic [4:0] s, logic [4:0] t, logic [4:0] d,
                                        logic [5:0] fn);
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                        logic [15:0] imm);
    return {op, s, t, imm};
  endfunction

  task automatic put(logic [4:0] i, logic [31:0] v);
    if (i != 5'd0) ref_reg[i] = v;   // R7: model drops writes to register 0
  endtask

  // Drive one instruction, check its combinational outputs, update the model.
  task automatic step(logic [31:0] ins);
    logic [5:0]  op, fn;
    logic [4:0]  s, t, d;
    logic [31:0] a, b, sx, zx, ea, nxt;
    string       req;
    op = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11]; fn = ins[5:0];
    check_eq({pc_req, " fetch address"}, imem_addr, ref_pc);
    imem_data = ins;
    #1;
    a   = rget(s);               // R10: operands read before this cycle's write
    b   = rget(t);
    sx  = 32'($signed(ins[15:0]));
    zx  = {16'h0000, ins[15:0]};
    ea  = a + sx;
    nxt = ref_pc + 32'd4;
    req = "R9";
    if (op == 6'h00 && fn == 6'h21) begin put(d, a + b); req = "R2"; end
    else if (op == 6'h00 && fn == 6'h23) begin put(d, a - b); req = "R2"; end
    else if (op == 6'h0D) begin put(t, a | zx); req = "R3"; end
    else if (op == 6'h23) begin
      check_eq("R4 load address", dmem_addr, ea);
      put(t, ref_mem[ea[9:2]]);
      req = "R4";
    end
    else if (op == 6'h2B) begin
      check_eq("R5 store strobe", {31'b0, dmem_we}, 32'd1);
      check_eq("R5 store address", dmem_addr, ea);
      check_eq("R5 store data", dmem_wdata, b);
      ref_mem[ea[9:2]] = b;
      req = "R5";
    end
    else if (op == 6'h04) begin
      if (a == b) nxt = ref_pc + 32'd4 + (sx << 2);
      req = "R6";
    end
    else req = "R8";
    if (op != 6'h2B) check_eq({req, " no store strobe"}, {31'b0, dmem_we}, 32'd0);
    ref_pc = nxt;
    pc_req = req;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WDOG);
        report();
      end
    end
  end

  initial begin
    void'($urandom(32'd61));
    for (int i = 0; i < MEM_WORDS; i++) begin
      dmem[i]    = (i * 32'h01030507) ^ 32'h9E3779B9;
      ref_mem[i] = (i * 32'h01030507) ^ 32'h9E3779B9;
    end
    for (int i = 0; i < 32; i++) ref_reg[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ref_pc = 32'h0;
    check_eq("R1 pc after reset", imem_addr, 32'h0);

    // Fill every register from register 0 (R3 zero-extension path).
    for (int k = 1; k < 32; k++) step(enc_i(6'h0D, 5'd0, 5'(k), 16'(k * 4099 + 17)));

    // R7: write to register 0 is lost, store of it gives zero.
    step(enc_i(6'h0D, 5'd0, 5'd0, 16'hFFFF));
    step(enc_i(6'h2B, 5'd0, 5'd0, 16'h0010));
    // R3: top immediate bit is not replicated.
    step(enc_i(6'h0D, 5'd0, 5'd7, 16'h8000));
    step(enc_i(6'h2B, 5'd0, 5'd7, 16'h0014));
    // R2: subtraction wraps.
    step(enc_r(5'd0, 5'd7, 5'd8, 6'h23));
    step(enc_i(6'h2B, 5'd0, 5'd8, 16'h0018));
    // R10: source and destination are the same register.
    step(enc_r(5'd5, 5'd5, 5'd5, 6'h21));
    step(enc_i(6'h2B, 5'd0, 5'd5, 16'h001C));
    // R4: negative load offset.
    step(enc_i(6'h23, 5'd20, 5'd9, 16'hFFFC));
    step(enc_i(6'h2B, 5'd0, 5'd9, 16'h0020));
    // R6: taken self-branch, then a branch on unequal registers.
    step(enc_i(6'h04, 5'd1, 5'd1, 16'hFFFF));
    step(enc_i(6'h04, 5'd1, 5'd2, 16'h0040));
    // R8: unknown opcode and unknown funct.
    step({6'h3F, 5'd3, 5'd4, 16'hFFFF});
    step(enc_r(5'd3, 5'd4, 5'd4, 6'h20));
    step(enc_i(6'h2B, 5'd0, 5'd4, 16'h0024));

    for (int n = 0; n < RAND_STEPS; n++) begin
      logic [4:0]  rs_r, rt_r, rd_r;
      logic [15:0] im;
      int          kind;
      rs_r = 5'($urandom); rt_r = 5'($urandom); rd_r = 5'($urandom);
      im   = 16'($urandom);
      kind = int'($urandom % 9);
      case (kind)
        0: step(enc_r(rs_r, rt_r, rd_r, 6'h21));
        1: step(enc_r(rs_r, rt_r, rd_r, 6'h23));
        2: step(enc_i(6'h0D, rs_r, rt_r, im));
        3: step(enc_i(6'h23, rs_r, rt_r, im));
        4: step(enc_i(6'h2B, rs_r, rt_r, im));
        5: step(enc_i(6'h04, rs_r, rt_r, im));
        6: step(enc_i(6'h04, rs_r, rs_r, im));
        7: step({6'($urandom % 3 + 6'h30), rs_r, rt_r, im});
        default: step(enc_r(rs_r, rt_r, rd_r, 6'($urandom % 32)));
      endcase
    end

    // R1: reset mid-run returns PC to 0 and leaves registers intact.
    rst = 1'b1;
    imem_data = 32'h0;
    @(negedge clk);
    rst = 1'b0;
    ref_pc = 32'h0;
    pc_req = "R1";
    check_eq("R1 pc after mid-run reset", imem_addr, 32'h0);
    for (int k = 0; k < 32; k++) step(enc_i(6'h2B, 5'd0, 5'(k), 16'(16'h0100 + k * 4)));

    report();
  end
endmodule